// File: doc/BRIEF.md
# Partial-Word Store Byte-Lane Generator

This block takes a request to store part of a register and turns it into one aligned memory write with per-byte enables. A request carries a byte address, a 64-bit value, a fragment mode and a unit size. The unit is either a 4-byte word or an 8-byte doubleword. In head mode the block writes the bytes from the addressed byte to the end of the unit. In tail mode it writes the bytes from the start of the unit up to, but not including, the addressed byte. Memory is big-endian, so byte 0 of a unit holds the most significant bits.

The block always places the selected fragment in a single masked beat on an 8-byte bus. This keeps fragments of 3, 5, 6 or 7 bytes atomic, because they are never split into smaller stores. A tail-mode request at an aligned address enables no bytes. The beat is still issued, with a probe-only flag, so that the memory side can run its write-permission check and mark the line dirty.

Requests enter through a valid/ready handshake and leave through a registered valid/ready output stage. Alignment faults and the memory itself are handled outside the block.

Top module: `sbl_store_lanes`

## Requirements
- R1: After a synchronous active-low reset, `wr_valid` is 0 and `req_ready` is 1.
- R2: `wr_addr` is `req_addr` with bits [1:0] cleared for a word request and bits [2:0] cleared for a doubleword request.
- R3: Bit n of `wr_be` enables byte offset n (0..7) of the aligned doubleword. That byte travels on `wr_data[63-8n -: 8]`. Every lane whose enable is 0 carries zero data.
- R4: A word request in head mode (`req_tail`=0) with k = `req_addr[1:0]` enables word bytes k..3. Word byte p carries `req_data[31-8p -: 8]`, so 4-k bytes are taken from the low end of the value.
- R5: A word request in tail mode (`req_tail`=1) with k = `req_addr[1:0]` enables word bytes 0..k-1. These bytes carry the top k bytes of `req_data[31:0]`.
- R6: A word request places its word on lanes 0..3 when `req_addr[2]`=0 and on lanes 4..7 when `req_addr[2]`=1. `req_data[63:32]` has no effect on a word request.
- R7: A doubleword request (`req_dword`=1) in head mode with k = `req_addr[2:0]` enables lanes k..7, which carry the low 8-k bytes of `req_data`. At k=0 all 8 bytes are written.
- R8: A doubleword request in tail mode with k = `req_addr[2:0]` enables lanes 0..k-1, which carry the top k bytes of `req_data`.
- R9: A tail-mode request at unit offset 0 drives `wr_be`=0 and `wr_probe`=1. Every other request drives `wr_probe`=0 with a nonzero `wr_be`.
- R10: Each accepted request produces exactly one output beat, one clock after acceptance. Back-to-back requests are accepted in consecutive cycles when the output is not stalled.
- R11: While `wr_valid`=1 and `wr_ready`=0, every output holds its value and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | 64 | Register value to store |
| req_tail | input | 1 | 0 = head mode, 1 = tail mode |
| req_dword | input | 1 | 0 = word unit, 1 = doubleword unit |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory side takes the beat |
| wr_addr | output | ADDR_W | Aligned write address |
| wr_data | output | 64 | Write data, big-endian lanes, disabled lanes zero |
| wr_be | output | 8 | Byte enables, bit n = byte offset n |
| wr_probe | output | 1 | Beat writes no bytes, permission probe only |

## Verification
A wrong mask or offset decode shows up at the ports on the beat that follows the request. It appears either as the wrong enable bits or as nonzero data on a disabled lane, and both are visible one clock after acceptance. A fault in the output register shows up either as a lost or doubled beat, which the bench catches by counting beats against requests, or as data that changes while the memory side stalls. The probe flag is compared against an empty enable mask on every beat, so an aligned tail request that is dropped or that writes bytes is exposed at once.

// File: rtl/sbl_pkg.sv
// Package: shared encodings for the store byte-lane generator.
// Assumes an 8-byte big-endian data bus.
package sbl_pkg;
    // Fragment direction selected by the request.
    typedef enum logic {
        FRAG_HEAD = 1'b0,
        FRAG_TAIL = 1'b1
    } frag_mode_e;

    // Unit size selected by the request.
    typedef enum logic {
        UNIT_WORD  = 1'b0,
        UNIT_DWORD = 1'b1
    } unit_size_e;

    localparam int unsigned LANE_BITS = 8;
endpackage

// File: rtl/sbl_lane_mask.sv
// Module: sbl_lane_mask
// Computes the byte-enable mask and probe flag for one request from the
// low address bits, the fragment mode and the unit size. Purely
// combinational. Assumes BUS_BYTES is a power of two and at least 4; a
// word unit is half the bus.
module sbl_lane_mask
    import sbl_pkg::*;
#(
    parameter int unsigned BUS_BYTES = 8
) (
    input  logic [$clog2(BUS_BYTES)-1:0] offs,
    input  unit_size_e                   size,
    input  frag_mode_e                   mode,
    output logic [BUS_BYTES-1:0]         be,
    output logic                         probe
);
    localparam int unsigned OFF_W = $clog2(BUS_BYTES);
    localparam int unsigned HALF  = BUS_BYTES / 2;

    logic [OFF_W-1:0] unit_off;

    // Offset of the addressed byte within its unit.
    always_comb begin
        if (size == UNIT_DWORD) begin
            unit_off = offs;
        end else begin
            unit_off = {1'b0, offs[OFF_W-2:0]};
        end
    end

    generate
        for (genvar j = 0; j < BUS_BYTES; j++) begin : g_lane
            localparam logic [OFF_W-1:0] POS_D = OFF_W'(j);
            localparam logic [OFF_W-1:0] POS_W = OFF_W'(j % HALF);
            localparam logic             HALF_J = (j / HALF) != 0;
            logic             in_unit;
            logic [OFF_W-1:0] pos;

            // Decide whether this lane belongs to the fragment.
            always_comb begin
                in_unit = (size == UNIT_DWORD) || (offs[OFF_W-1] == HALF_J);
                pos     = (size == UNIT_DWORD) ? POS_D : POS_W;
                if (mode == FRAG_TAIL) begin
                    be[j] = in_unit && (pos < unit_off);
                end else begin
                    be[j] = in_unit && (pos >= unit_off);
                end
            end
        end
    endgenerate

    // An aligned tail fragment is empty and becomes a probe.
    always_comb begin
        probe = (mode == FRAG_TAIL) && (unit_off == '0);
    end
endmodule

// File: rtl/sbl_lane_place.sv
// Module: sbl_lane_place
// Routes value bytes onto big-endian bus lanes and zeroes each disabled
// lane. A word takes its source bytes from the low half of the value and
// is copied to both halves before masking. Purely combinational.
module sbl_lane_place
    import sbl_pkg::*;
#(
    parameter int unsigned BUS_BYTES = 8
) (
    input  logic [BUS_BYTES*LANE_BITS-1:0] value,
    input  unit_size_e                     size,
    input  logic [BUS_BYTES-1:0]           be,
    output logic [BUS_BYTES*LANE_BITS-1:0] wdata
);
    localparam int unsigned HALF = BUS_BYTES / 2;

    generate
        for (genvar j = 0; j < BUS_BYTES; j++) begin : g_lane
            localparam int unsigned DST   = (BUS_BYTES - 1 - j) * LANE_BITS;
            localparam int unsigned SRC_W = (HALF - 1 - (j % HALF)) * LANE_BITS;
            logic [LANE_BITS-1:0] src;

            // Pick the source byte for this lane and gate it by its enable.
            always_comb begin
                src = (size == UNIT_DWORD) ? value[DST +: LANE_BITS]
                                           : value[SRC_W +: LANE_BITS];
                wdata[DST +: LANE_BITS] = be[j] ? src : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/sbl_out_stage.sv
// Module: sbl_out_stage
// One-entry registered valid/ready stage. It accepts a new payload when it
// is empty or when its current payload leaves in the same cycle, and holds
// the payload while stalled. Synchronous active-low reset.
module sbl_out_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_payload,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_payload
);
    // Accept when empty or draining.
    always_comb begin
        in_ready = !out_valid || out_ready;
    end

    // Track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    // Capture the payload on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_payload <= '0;
        end else if (in_ready && in_valid) begin
            out_payload <= in_payload;
        end
    end
endmodule

// File: rtl/sbl_store_lanes.sv
// Module: sbl_store_lanes
// Turns a partial-word store request (head or tail fragment of a word or
// doubleword) into one aligned, byte-masked write beat on an 8-byte
// big-endian bus. The output is registered behind a valid/ready stage.
// Assumes BUS_BYTES = 8 with a 4-byte word.
module sbl_store_lanes
    import sbl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BUS_BYTES = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [BUS_BYTES*LANE_BITS-1:0] req_data,
    input  logic                           req_tail,
    input  logic                           req_dword,
    output logic                           wr_valid,
    input  logic                           wr_ready,
    output logic [ADDR_W-1:0]              wr_addr,
    output logic [BUS_BYTES*LANE_BITS-1:0] wr_data,
    output logic [BUS_BYTES-1:0]           wr_be,
    output logic                           wr_probe
);
    localparam int unsigned DATA_W = BUS_BYTES * LANE_BITS;
    localparam int unsigned OFF_W  = $clog2(BUS_BYTES);
    localparam int unsigned HALF   = BUS_BYTES / 2;
    localparam int unsigned PAY_W  = ADDR_W + DATA_W + BUS_BYTES + 1;

    frag_mode_e          mode;
    unit_size_e          size;
    logic [BUS_BYTES-1:0] be_c;
    logic                probe_c;
    logic [DATA_W-1:0]   wdata_c;
    logic [ADDR_W-1:0]   addr_c;
    logic [PAY_W-1:0]    pay_in;
    logic [PAY_W-1:0]    pay_out;

    // Map raw request bits onto the shared encodings.
    always_comb begin
        mode = req_tail  ? FRAG_TAIL  : FRAG_HEAD;
        size = req_dword ? UNIT_DWORD : UNIT_WORD;
    end

    sbl_lane_mask #(.BUS_BYTES(BUS_BYTES)) u_mask (
        .offs  (req_addr[OFF_W-1:0]),
        .size  (size),
        .mode  (mode),
        .be    (be_c),
        .probe (probe_c)
    );

    sbl_lane_place #(.BUS_BYTES(BUS_BYTES)) u_place (
        .value (req_data),
        .size  (size),
        .be    (be_c),
        .wdata (wdata_c)
    );

    // Clear the low address bits that lie inside the unit.
    always_comb begin
        if (size == UNIT_DWORD) begin
            addr_c = req_addr & ~ADDR_W'(BUS_BYTES - 1);
        end else begin
            addr_c = req_addr & ~ADDR_W'(HALF - 1);
        end
        pay_in = {addr_c, wdata_c, be_c, probe_c};
    end

    sbl_out_stage #(.W(PAY_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (req_valid),
        .in_ready    (req_ready),
        .in_payload  (pay_in),
        .out_valid   (wr_valid),
        .out_ready   (wr_ready),
        .out_payload (pay_out)
    );

    // Unpack the registered beat onto the output ports.
    always_comb begin
        {wr_addr, wr_data, wr_be, wr_probe} = pay_out;
    end
endmodule

// File: rtl/sbl_store_lanes_chk.sv
// Module: sbl_store_lanes_chk
// Port-level protocol and lane checks for sbl_store_lanes, attached by bind.
module sbl_store_lanes_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BUS_BYTES = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic                     wr_valid,
    input logic                     wr_ready,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [BUS_BYTES*8-1:0]   wr_data,
    input logic [BUS_BYTES-1:0]     wr_be,
    input logic                     wr_probe
);
    logic [BUS_BYTES*8-1:0] lane_fill;
    logic                   lanes_clean;

    // Expand enables into a bit mask to find data on disabled lanes.
    always_comb begin
        for (int j = 0; j < BUS_BYTES; j++) begin
            lane_fill[(BUS_BYTES-1-j)*8 +: 8] = {8{wr_be[j]}};
        end
        lanes_clean = (wr_data & ~lane_fill) == '0;
    end

    a_r10_accept_gives_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> wr_valid);

    a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_be)
                                     && $stable(wr_addr) && $stable(wr_probe)));

    a_r11_no_accept_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> !req_ready);

    a_r9_probe_iff_empty: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_probe == (wr_be == '0)));

    a_r3_idle_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> lanes_clean);

    a_r2_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00));
endmodule

bind sbl_store_lanes sbl_store_lanes_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .wr_probe  (wr_probe)
);

// File: tb/sbl_store_lanes_test.sv
`timescale 1ns/1ps
module sbl_store_lanes_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic        req_tail = 1'b0;
    logic        req_dword = 1'b0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_be;
    logic        wr_probe;

    int checks = 0;
    int errors = 0;
    int beats  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sbl_store_lanes uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_tail(req_tail),
        .req_dword(req_dword), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_probe(wr_probe)
    );

    always @(posedge clk) if (rst_n && wr_valid && wr_ready) beats <= beats + 1;

    task automatic chk(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Reference: walk the byte addresses of the aligned doubleword.
    task automatic model(input logic [31:0] a, input logic [63:0] v, input bit tail,
                         input bit dw, output logic [31:0] ea, output logic [63:0] ed,
                         output logic [7:0] eb, output bit ep);
        longint u  = dw ? 8 : 4;
        longint us = longint'(a) & ~(u - 1);
        longint a8 = longint'(a) & ~longint'(7);
        ed = '0; eb = '0;
        for (int b = 0; b < 8; b++) begin
            longint ba = a8 + b;
            if (ba >= us && ba < us + u) begin
                bit take = tail ? (ba < longint'(a)) : (ba >= longint'(a));
                if (take) begin
                    logic [63:0] sh = v >> (8 * (u - 1 - (ba - us)));
                    eb[b] = 1'b1;
                    ed[63-8*b -: 8] = sh[7:0];
                end
            end
        end
        ea = 32'(us);
        ep = (eb == '0);
    endtask

    task automatic drive(input logic [31:0] a, input logic [63:0] v, input bit tail,
                         input bit dw);
        req_addr = a; req_data = v; req_tail = tail; req_dword = dw; req_valid = 1'b1;
    endtask

    task automatic check_out(input logic [31:0] a, input logic [63:0] v, input bit tail,
                             input bit dw, input string tag);
        logic [31:0] ea; logic [63:0] ed; logic [7:0] eb; bit ep;
        model(a, v, tail, dw, ea, ed, eb, ep);
        chk(wr_valid == 1'b1, {tag, " valid (R10)"}, 64'(wr_valid), 64'd1);
        chk(wr_addr == ea, {tag, " addr (R2)"}, 64'(wr_addr), 64'(ea));
        chk(wr_be == eb, {tag, " be"}, 64'(wr_be), 64'(eb));
        chk(wr_data == ed, {tag, " data (R3 lanes)"}, wr_data, ed);
        chk(wr_probe == ep, {tag, " probe (R9)"}, 64'(wr_probe), 64'(ep));
    endtask

    // One request, one beat, checked one clock after acceptance.
    task automatic run_req(input logic [31:0] a, input logic [63:0] v, input bit tail,
                           input bit dw, input string tag);
        int b0;
        @(negedge clk);
        b0 = beats;
        drive(a, v, tail, dw);
        @(negedge clk);
        req_valid = 1'b0;
        check_out(a, v, tail, dw, tag);
        @(negedge clk);
        chk(beats == b0 + 1, {tag, " one beat (R10)"}, 64'(beats - b0), 64'd1);
        chk(wr_valid == 1'b0, {tag, " drained (R10)"}, 64'(wr_valid), 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(wr_valid == 1'b0, "R1 wr_valid after reset", 64'(wr_valid), 64'd0);
        chk(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'd1);
    endtask

    task automatic t_word_head;
        for (int k = 0; k < 8; k++)
            run_req(32'h0000_1200 + 32'(k), 64'hA1A2A3A4_11223344, 1'b0, 1'b0, "R4 R6 word head");
    endtask

    task automatic t_word_tail;
        for (int k = 0; k < 8; k++)
            run_req(32'h0000_3400 + 32'(k), 64'hF0E0D0C0_5566778A, 1'b1, 1'b0, "R5 R6 word tail");
    endtask

    task automatic t_dword_head;
        for (int k = 0; k < 8; k++)
            run_req(32'h0001_0008 + 32'(k), 64'h0123456789ABCDEF, 1'b0, 1'b1, "R7 dword head");
    endtask

    task automatic t_dword_tail;
        for (int k = 0; k < 8; k++)
            run_req(32'h0002_0010 + 32'(k), 64'hFEDCBA9876543210, 1'b1, 1'b1, "R8 dword tail");
    endtask

    task automatic t_probe;
        run_req(32'h0000_0104, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R9 word aligned tail");
        run_req(32'h0000_0200, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, "R9 dword aligned tail");
    endtask

    // Word requests differing only in data[63:32] give identical beats.
    task automatic t_upper_ignored;
        logic [63:0] d1, d2;
        logic [7:0]  b1, b2;
        @(negedge clk); drive(32'h0000_0505, 64'h00000000_CAFEBABE, 1'b0, 1'b0);
        @(negedge clk); d1 = wr_data; b1 = wr_be;
        drive(32'h0000_0505, 64'hDEADBEEF_CAFEBABE, 1'b0, 1'b0);
        @(negedge clk); req_valid = 1'b0; d2 = wr_data; b2 = wr_be;
        chk(d1 == d2, "R6 upper half ignored data", d2, d1);
        chk(b1 == b2, "R6 upper half ignored be", 64'(b2), 64'(b1));
        chk(d2 == 64'h00000000_00FEBABE, "R6 lanes 5..7 used", d2, 64'h00000000_00FEBABE);
        @(negedge clk);
    endtask

    // Back-to-back requests accepted in consecutive cycles.
    task automatic t_back_to_back;
        int b0;
        @(negedge clk); b0 = beats;
        drive(32'h0000_0A03, 64'h1111111122334455, 1'b1, 1'b1);
        @(negedge clk);
        check_out(32'h0000_0A03, 64'h1111111122334455, 1'b1, 1'b1, "R10 b2b first");
        drive(32'h0000_0A06, 64'h9988776655443322, 1'b0, 1'b0);
        @(negedge clk);
        check_out(32'h0000_0A06, 64'h9988776655443322, 1'b0, 1'b0, "R10 b2b second");
        req_valid = 1'b0;
        @(negedge clk);
        chk(beats == b0 + 2, "R10 b2b beat count", 64'(beats - b0), 64'd2);
    endtask

    task automatic t_stall;
        int b0;
        logic [63:0] held;
        @(negedge clk); b0 = beats; wr_ready = 1'b0;
        drive(32'h0000_0C05, 64'h0102030405060708, 1'b0, 1'b1);
        @(negedge clk);
        check_out(32'h0000_0C05, 64'h0102030405060708, 1'b0, 1'b1, "R11 stalled beat");
        chk(req_ready == 1'b0, "R11 req_ready low while stalled", 64'(req_ready), 64'd0);
        held = wr_data;
        drive(32'h0000_0C02, 64'hAABBCCDDEEFF0011, 1'b1, 1'b0);
        @(negedge clk);
        chk(wr_data == held, "R11 data held", wr_data, held);
        chk(beats == b0, "R11 no beat while stalled", 64'(beats - b0), 64'd0);
        wr_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_out(32'h0000_0C02, 64'hAABBCCDDEEFF0011, 1'b1, 1'b0, "R11 queued request");
        chk(beats == b0 + 1, "R11 one beat on release", 64'(beats - b0), 64'd1);
        @(negedge clk);
        chk(beats == b0 + 2, "R10 both beats delivered", 64'(beats - b0), 64'd2);
        chk(wr_valid == 1'b0, "R10 idle after drain", 64'(wr_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_word_head();
        t_word_tail();
        t_dword_head();
        t_dword_tail();
        t_probe();
        t_upper_ignored();
        t_back_to_back();
        t_stall();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule